// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit path from a ring of 8-byte buffer descriptors that software keeps in memory. A one-cycle demand strobe, taken only while the controller enable input is high, starts a walk at the current descriptor pointer. Each descriptor is read over a word-wide memory port. If hardware owns it, the referenced buffer is fetched one 32-bit word at a time and sent out as a byte stream under a valid/ready handshake. The final byte of a frame carries a last marker. Each consumed descriptor is then returned to software: the ownership bit is cleared and the flags/length word is written back.

The walk moves from descriptor to descriptor. The next pointer is either the current one plus eight or, when the descriptor asks to wrap, the programmable ring base. The walk ends at the first descriptor that hardware does not own, and the pointer is kept there for the next demand. Bytes gathered into one frame are capped at a parameterised maximum (2032 by default). A buffer that would cross the cap is cut short and raises a truncation event. Per-buffer, per-frame and truncation events are one-cycle pulses.

Top module: `txring_walker`

## Requirements
- R1: A descriptor at word-aligned address P holds flags in bits 31:16 and the byte count in bits 15:0 of the word at P, and the buffer address in the word at P+4 (its low two bits ignored). A demand strobe with the enable high, while idle, starts reading at the current pointer, and every memory request address is word-aligned.
- R2: When a descriptor read has flags bit 15 (ready) clear, the walk stops without a write-back, stream bytes or events, and the pointer stays at that descriptor, so the next demand re-reads it.
- R3: A ready buffer is emitted as exactly its effective byte count, one byte per accepted transfer, in rising address order, with the most significant byte of each memory word first. While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold.
- R4: tx_last is high only on the final byte of a buffer whose flags bit 11 (last) is set.
- R5: After the bytes of a buffer are emitted, the word at P is written back with bit 31 cleared and all other bits unchanged. ev_buf_done then pulses for one cycle.
- R6: For a buffer with flags bit 11 set, ev_frame_done pulses in the same cycle as ev_buf_done, and the gathered byte count restarts at zero for the next frame.
- R7: After a write-back, the next descriptor address is the ring base if flags bit 13 (wrap) was set, and P+8 otherwise.
- R8: Bytes gathered into one frame never exceed MAX_FRAME. A buffer that would cross the cap contributes only the remaining room, and ev_babble pulses together with that buffer's ev_buf_done.
- R9: A demand strobe while ctrl_en is low is ignored: busy stays low and no memory request is issued.
- R10: A ring-base write while idle stores the value with bits 1:0 forced to zero and reloads the current pointer with it.
- R11: busy is high from an accepted demand until the walk stops, and while it is low no memory request or stream byte is offered. A memory request holds its address and direction until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; demands count only while high |
| kick | input | 1 | One-cycle transmit demand strobe |
| base_we | input | 1 | Ring-base write strobe |
| base_wdata | input | ADDR_W | Ring-base value |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address, word-aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte offered |
| tx_ready | input | 1 | Stream sink accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| ev_buf_done | output | 1 | Buffer consumed pulse |
| ev_frame_done | output | 1 | Frame finished pulse |
| ev_babble | output | 1 | Frame cut at the cap pulse |
| busy | output | 1 | Walk in progress |

## Verification
The truncation event, the buffer-done event and the frame-done event can fall in one cycle. This happens when a last-marked buffer is the one that crosses the frame cap. The bench provokes it with a 2000-byte buffer followed by a 40-byte last buffer. It judges the event monitor's record of a cycle that has all three pulses, and checks that exactly 32 bytes of the second buffer appear with the last marker on the 2032nd byte. A following 4-byte frame must then stream in full with no truncation event, which shows that the gathered count restarted.

// File: rtl/txw_pkg.sv
package txw_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int DESC_BYTES = 8;
    localparam int FLAG_OWN   = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_HDR,
        S_WT_HDR,
        S_RD_PTR,
        S_WT_PTR,
        S_RD_BUF,
        S_WT_BUF,
        S_STREAM,
        S_WRBACK
    } walk_state_e;
endpackage

// File: rtl/txw_len_cap.sv
module txw_len_cap #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2032
) (
    input  logic [LEN_W-1:0] gathered,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] eff_len,
    output logic             cut
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_FRAME);

    logic [LEN_W-1:0] room;

    always_comb begin
        room    = (gathered >= CAP) ? '0 : CAP - gathered;
        cut     = req_len > room;
        eff_len = cut ? room : req_len;
    end
endmodule

// File: rtl/txw_byte_sel.sv
module txw_byte_sel #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]               word,
    input  logic [$clog2(WORD_W/8)-1:0]     lane,
    output logic [7:0]                      byte_out
);
    localparam int LANES = WORD_W / 8;

    logic [7:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[WORD_W-1-8*g -: 8];
    end

    assign byte_out = lane_bytes[lane];
endmodule

// File: rtl/txw_next_ptr.sv
module txw_next_ptr #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base,
    input  logic              wrap,
    output logic [ADDR_W-1:0] nxt
);
    assign nxt = wrap ? base : cur + ADDR_W'(DESC_BYTES);
endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              kick,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              ev_buf_done,
    output logic              ev_frame_done,
    output logic              ev_babble,
    output logic              busy
);
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LANES - 1);

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] base;
        logic [15:0]       flags;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] bufa;
        logic [LEN_W-1:0]  eff;
        logic              cut;
        logic [LEN_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  gathered;
        logic              ev_buf;
        logic              ev_frm;
        logic              ev_bab;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [LEN_W-1:0]  cap_eff;
    logic              cap_cut;
    logic [7:0]        lane_byte;
    logic [ADDR_W-1:0] next_desc;
    logic [LEN_W-1:0]  cnt_inc;

    txw_len_cap #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_cap (
        .gathered (r_q.gathered),
        .req_len  (r_q.len),
        .eff_len  (cap_eff),
        .cut      (cap_cut)
    );

    txw_byte_sel #(.WORD_W(WORD_W)) u_sel (
        .word     (r_q.word),
        .lane     (r_q.cnt[LANE_W-1:0]),
        .byte_out (lane_byte)
    );

    txw_next_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_next (
        .cur  (r_q.cur),
        .base (r_q.base),
        .wrap (r_q.flags[FLAG_WRAP]),
        .nxt  (next_desc)
    );

    assign cnt_inc = r_q.cnt + LEN_W'(1);

    always_comb begin
        r_d           = r_q;
        r_d.ev_buf    = 1'b0;
        r_d.ev_frm    = 1'b0;
        r_d.ev_bab    = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        tx_valid      = 1'b0;
        tx_last       = 1'b0;
        tx_data       = lane_byte;

        case (r_q.st)
            S_IDLE: begin
                if (kick && ctrl_en) begin
                    r_d.st = S_RD_HDR;
                end
            end
            S_RD_HDR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = r_q.cur;
                if (mem_req_ready) r_d.st = S_WT_HDR;
            end
            S_WT_HDR: begin
                if (mem_rsp_valid) begin
                    r_d.flags = mem_rsp_rdata[31:16];
                    r_d.len   = mem_rsp_rdata[LEN_W-1:0];
                    r_d.st    = mem_rsp_rdata[16+FLAG_OWN] ? S_RD_PTR : S_IDLE;
                end
            end
            S_RD_PTR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = r_q.cur + ADDR_W'(4);
                if (mem_req_ready) r_d.st = S_WT_PTR;
            end
            S_WT_PTR: begin
                if (mem_rsp_valid) begin
                    r_d.bufa     = ADDR_W'(mem_rsp_rdata) & ALIGN_MASK;
                    r_d.eff      = cap_eff;
                    r_d.cut      = cap_cut;
                    r_d.gathered = r_q.gathered + cap_eff;
                    r_d.cnt      = '0;
                    r_d.st       = (cap_eff == '0) ? S_WRBACK : S_RD_BUF;
                end
            end
            S_RD_BUF: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = r_q.bufa
                              + ADDR_W'({r_q.cnt[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
                if (mem_req_ready) r_d.st = S_WT_BUF;
            end
            S_WT_BUF: begin
                if (mem_rsp_valid) begin
                    r_d.word = mem_rsp_rdata;
                    r_d.st   = S_STREAM;
                end
            end
            S_STREAM: begin
                tx_valid = 1'b1;
                tx_last  = r_q.flags[FLAG_LAST] && (cnt_inc == r_q.eff);
                if (tx_ready) begin
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == r_q.eff) begin
                        r_d.st = S_WRBACK;
                    end else if (r_q.cnt[LANE_W-1:0] == LANE_W'(LANES - 1)) begin
                        r_d.st = S_RD_BUF;
                    end
                end
            end
            S_WRBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = r_q.cur;
                mem_req_wdata = {r_q.flags & ~(16'h1 << FLAG_OWN), r_q.len};
                if (mem_req_ready) begin
                    r_d.ev_buf = 1'b1;
                    r_d.ev_frm = r_q.flags[FLAG_LAST];
                    r_d.ev_bab = r_q.cut;
                    r_d.cur    = next_desc;
                    if (r_q.flags[FLAG_LAST]) r_d.gathered = '0;
                    r_d.st     = S_RD_HDR;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (base_we && r_q.st == S_IDLE) begin
            r_d.base = base_wdata & ALIGN_MASK;
            r_d.cur  = base_wdata & ALIGN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ev_buf_done   = r_q.ev_buf;
    assign ev_frame_done = r_q.ev_frm;
    assign ev_babble     = r_q.ev_bab;
    assign busy          = r_q.st != S_IDLE;
endmodule

// File: rtl/txw_checker.sv
module txw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_en,
    input logic              kick,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [31:0]       mem_req_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              ev_buf_done,
    input logic              ev_frame_done,
    input logic              ev_babble,
    input logic              busy
);
    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_wb_owner_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> !mem_req_wdata[31]);

    p_frame_with_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_done |-> ev_buf_done);

    p_babble_with_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_babble |-> ev_buf_done);

    p_kick_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && kick && !ctrl_en |=> !busy);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !tx_valid);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
endmodule

bind txring_walker txw_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_en       (ctrl_en),
    .kick          (kick),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .tx_last       (tx_last),
    .ev_buf_done   (ev_buf_done),
    .ev_frame_done (ev_frame_done),
    .ev_babble     (ev_babble),
    .busy          (busy)
);

// File: tb/txring_walker_tb_top.sv
`timescale 1ns/1ps
module txring_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b0;
    logic        kick = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        ev_buf_done, ev_frame_done, ev_babble, busy;

    always #10 clk = ~clk;

    txring_walker dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .kick(kick),
        .base_we(base_we), .base_wdata(base_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .ev_buf_done(ev_buf_done),
        .ev_frame_done(ev_frame_done), .ev_babble(ev_babble), .busy(busy)
    );

    int total = 0;
    int bad   = 0;

    logic [31:0] mem [0:4095];
    logic [15:0] lfsr = 16'hACE1;
    logic        pend = 1'b0;
    logic [31:0] pdata = '0;
    int          nreq = 0;
    int          nbuf = 0, nfrm = 0, nbab = 0, ncoinc = 0;
    logic        cap_first = 1'b0;
    logic [31:0] first_addr = '0;
    logic [7:0]  got_b [$];
    logic        got_l [$];
    logic [7:0]  exp_b [$];
    logic        exp_l [$];

    function automatic logic [7:0] pb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5a;
    endfunction

    // memory model and stream/event monitor, all on the falling edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = pdata;
            pend = 1'b0;
        end
        mem_req_ready = lfsr[3:2] != 2'b00;
        tx_ready      = lfsr[7:6] != 2'b00;
        if (mem_req_valid && mem_req_ready) begin
            nreq++;
            if (cap_first) begin
                first_addr = mem_req_addr;
                cap_first  = 1'b0;
            end
            if (mem_req_write) mem[mem_req_addr[13:2]] = mem_req_wdata;
            else begin
                pend  = 1'b1;
                pdata = mem[mem_req_addr[13:2]];
            end
        end
        if (tx_valid && tx_ready) begin
            got_b.push_back(tx_data);
            got_l.push_back(tx_last);
        end
        if (ev_buf_done)   nbuf++;
        if (ev_frame_done) nfrm++;
        if (ev_babble)     nbab++;
        if (ev_babble && ev_buf_done && ev_frame_done) ncoinc++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [15:0] fl,
                            input logic [15:0] ln, input logic [31:0] buf_a);
        mem[a[13:2]]     = {fl, ln};
        mem[a[13:2] + 1] = buf_a;
    endtask

    task automatic expect_buf(input logic [31:0] buf_a, input int n, input bit is_last);
        for (int i = 0; i < n; i++) begin
            exp_b.push_back(pb(buf_a + i));
            exp_l.push_back(is_last && (i == n - 1));
        end
    endtask

    task automatic clear_logs();
        got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
        nbuf = 0; nfrm = 0; nbab = 0; ncoinc = 0; nreq = 0;
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic demand_and_wait();
        cap_first = 1'b1;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        for (int t = 0; t < 30000 && busy; t++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        int mism = -1;
        int lpos = -1;
        chk(got_b.size() == exp_b.size(), req, "byte count", got_b.size(), exp_b.size());
        for (int i = 0; i < got_b.size() && i < exp_b.size(); i++) begin
            if (mism < 0 && got_b[i] != exp_b[i]) mism = i;
            if (lpos < 0 && got_l[i] != exp_l[i]) lpos = i;
        end
        chk(mism < 0, req, "byte content (first bad index)", mism, -1);
        chk(lpos < 0, "R4", "last marker (first bad index)", lpos, -1);
    endtask

    task automatic t_reset();
        chk(!busy && !mem_req_valid && !tx_valid, "R11", "idle after reset",
            {busy, mem_req_valid, tx_valid}, 0);
        chk(!ev_buf_done && !ev_frame_done && !ev_babble, "R5", "events low after reset",
            {ev_buf_done, ev_frame_done, ev_babble}, 0);
    endtask

    task automatic t_disabled();
        clear_logs();
        ctrl_en = 1'b0;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        chk(!busy, "R9", "busy after demand with enable low", busy, 0);
        repeat (5) @(negedge clk);
        chk(nreq == 0, "R9", "memory requests", nreq, 0);
        ctrl_en = 1'b1;
    endtask

    // two-buffer frame, base written unaligned, third descriptor not owned
    task automatic t_frame();
        clear_logs();
        put_desc(32'h100, 16'h8000, 16'd5, 32'h400);
        put_desc(32'h108, 16'h8800, 16'd6, 32'h502);
        put_desc(32'h110, 16'h0000, 16'd9, 32'h600);
        write_base(32'h0000_0103);
        expect_buf(32'h400, 5, 1'b0);
        expect_buf(32'h500, 6, 1'b1);
        demand_and_wait();
        chk(first_addr == 32'h100, "R10", "first request address", first_addr, 32'h100);
        cmp_stream("R3");
        chk(nbuf == 2, "R5", "buffer-done pulses", nbuf, 2);
        chk(nfrm == 1, "R6", "frame-done pulses", nfrm, 1);
        chk(mem[32'h100 >> 2] == 32'h0000_0005, "R5", "write-back word 0x100",
            mem[32'h100 >> 2], 32'h0000_0005);
        chk(mem[32'h108 >> 2] == 32'h0800_0006, "R5", "write-back word 0x108",
            mem[32'h108 >> 2], 32'h0800_0006);
        chk(mem[32'h110 >> 2] == 32'h0000_0009, "R2", "unowned descriptor untouched",
            mem[32'h110 >> 2], 32'h0000_0009);
        chk(nreq == 11, "R1", "request count for walk", nreq, 11);
    endtask

    // pointer kept at stopping descriptor; wrap returns to base
    task automatic t_resume_wrap();
        clear_logs();
        put_desc(32'h110, 16'hA800, 16'd3, 32'h600);
        expect_buf(32'h600, 3, 1'b1);
        demand_and_wait();
        chk(first_addr == 32'h110, "R2", "resume address", first_addr, 32'h110);
        cmp_stream("R3");
        chk(nbuf == 1 && nfrm == 1, "R6", "events for wrap buffer", {nbuf, nfrm}, 1 << 32 | 1);
        clear_logs();
        demand_and_wait();
        chk(first_addr == 32'h100, "R7", "address after wrap", first_addr, 32'h100);
        chk(got_b.size() == 0 && nbuf == 0, "R2", "no bytes or events on unowned",
            got_b.size() + nbuf, 0);
    endtask

    // cap crossing on a last buffer, then a fresh frame
    task automatic t_cap();
        clear_logs();
        put_desc(32'h200, 16'h8000, 16'd2000, 32'h1000);
        put_desc(32'h208, 16'h8800, 16'd40, 32'h2000);
        put_desc(32'h210, 16'h8800, 16'd4, 32'h2100);
        put_desc(32'h218, 16'h0000, 16'd0, 32'h0);
        write_base(32'h200);
        expect_buf(32'h1000, 2000, 1'b0);
        expect_buf(32'h2000, 32, 1'b1);
        expect_buf(32'h2100, 4, 1'b1);
        demand_and_wait();
        cmp_stream("R8");
        chk(nbab == 1, "R8", "truncation pulses", nbab, 1);
        chk(ncoinc == 1, "R8", "truncation with buffer and frame done", ncoinc, 1);
        chk(nfrm == 2 && nbuf == 3, "R6", "events across two frames",
            {nfrm, nbuf}, 2 << 32 | 3);
        chk(mem[32'h208 >> 2] == 32'h0800_0028, "R5", "write-back keeps length",
            mem[32'h208 >> 2], 32'h0800_0028);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            logic [31:0] a;
            a = 32'(i) << 2;
            mem[i] = {pb(a), pb(a + 1), pb(a + 2), pb(a + 3)};
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_frame();
        t_resume_wrap();
        t_cap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule